// File: doc/BRIEF.md
# Bit-Serial Multiplier-Free Butterfly

This block forms the two real outputs of one butterfly element, `A*cos(x) - B*sin(y)` and `A*cos(x) + B*sin(y)`, with no multiplier. The angles are fixed for each instance: their cosine and sine come in as signed fixed-point parameters. The operands A and B arrive together as two bit-serial two's-complement streams, least significant bit first. On each operand bit, the pair (a, b) selects one entry from a four-entry table of precomputed coefficient sums. That entry is shifted by the bit index and added into an accumulator. For the sign bit it is subtracted instead. Each of the two terms has its own table and its own accumulator.

When the sign bit has been absorbed, each accumulator holds its full product in fixed point. Each result is scaled down by the coefficient fraction, truncated to one bit wider than the operand, and loaded into an output shift register. Both results then leave side by side as serial streams, least significant bit first, ready for the next stage.

The controller is a four-state machine:
- **IDLE** waits for a valid bit carrying the first-bit strobe (transition *start*).
- **ACCUM** consumes valid operand bits. After the sign bit it takes transition *msb_done* to **DONE**.
- **DONE** lasts one cycle and raises `done` while loading the output registers (transition *load*).
- **SHIFT** drives the outputs for RW cycles and then takes transition *drained* back to **IDLE**.

Top module: `dabf_butterfly`

## Requirements
- R1: With C = COS_C and S = SIN_C, each taken as a signed value with FRAC fractional bits, the difference output `dif_bit` carries floor((A*C - B*S) / 2^FRAC) modulo 2^RW, where RW = DW+1 and A and B are DW-bit two's-complement operands.
- R2: The sum output `sum_bit` carries floor((A*C + B*S) / 2^FRAC) modulo 2^RW, with the same encoding as R1.
- R3: Operand bits enter least significant bit first. An operation starts on a cycle in IDLE where `bit_vld` and `bit_first` are both 1, and that cycle supplies bit 0. After that, bits are consumed only on cycles where `bit_vld` is 1, so idle cycles between bits leave the result unchanged.
- R4: Bit DW-1 of each operand carries negative weight −2^(DW-1), so negative operands, including the most negative value, give correct results.
- R5: Each operation starts from a cleared accumulator. A result never depends on the operands of an earlier operation.
- R6: `done` is high for exactly one cycle: the cycle after the cycle in which bit DW-1 is consumed. `out_vld` is low during that cycle.
- R7: `out_vld` is high for exactly RW consecutive cycles, starting the cycle after `done`. In those cycles `dif_bit` and `sum_bit` present result bits 0 to RW-1 in order. While `out_vld` is low, both output bits are 0.
- R8: Inputs arriving while the block is in DONE or SHIFT are ignored. They neither start an operation nor disturb the result being shifted out.
- R9: After reset, `done`, `out_vld`, `dif_bit` and `sum_bit` are all 0, and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Operand bits on `a_bit`/`b_bit` are valid this cycle |
| bit_first | input | 1 | Marks bit 0 of a new operand pair |
| a_bit | input | 1 | Serial bit of operand A, least significant bit first |
| b_bit | input | 1 | Serial bit of operand B, least significant bit first |
| done | output | 1 | One-cycle pulse after the sign bit has been absorbed |
| out_vld | output | 1 | Serial result bits are valid |
| dif_bit | output | 1 | Serial bit of A*cos − B*sin, least significant bit first |
| sum_bit | output | 1 | Serial bit of A*cos + B*sin, least significant bit first |

## Verification
A bad table entry or a wrong sign on the last accumulation step shows up in the serial words. It surfaces RW+1 cycles after the sign bit goes in. Operands at the most negative value make a missing negative weight visible as a large error in both terms. A left-over accumulator value shows as a wrong result on the very next operation, so unrelated operations are run back to back. A controller that miscounts bits or output cycles shows at once as a missing, early or stretched `done` or `out_vld`, and as nonzero output lines outside the valid window.

// File: rtl/dabf_pkg.sv
package dabf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_DONE,
        ST_SHIFT
    } dabf_state_t;
endpackage

// File: rtl/dabf_lut.sv
// Four-entry coefficient table addressed by one bit of each operand.
module dabf_lut #(
    parameter int CW = 10,
    parameter logic signed [CW-1:0] COS_C = '0,
    parameter logic signed [CW-1:0] SIN_C = '0,
    parameter bit NEG_SIN = 1'b1
) (
    input  logic              a_in,
    input  logic              b_in,
    output logic signed [CW:0] term
);
    localparam logic signed [CW:0] COS_E = {COS_C[CW-1], COS_C};
    localparam logic signed [CW:0] SIN_E = {SIN_C[CW-1], SIN_C};

    logic signed [CW:0] sin_t;

    generate
        if (NEG_SIN) begin : g_sub
            assign sin_t = -SIN_E;
        end else begin : g_add
            assign sin_t = SIN_E;
        end
    endgenerate

    always_comb begin
        unique case ({a_in, b_in})
            2'b00:   term = '0;
            2'b01:   term = sin_t;
            2'b10:   term = COS_E;
            default: term = COS_E + sin_t;
        endcase
    end
endmodule

// File: rtl/dabf_acc.sv
// Shift-accumulator: bit 0 loads (clearing any residue), the sign bit subtracts.
module dabf_acc #(
    parameter int CW = 10,
    parameter int AW = 19,
    parameter int SW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic               en,
    input  logic               neg,
    input  logic [SW-1:0]      sh,
    input  logic signed [CW:0] term,
    output logic signed [AW-1:0] acc
);
    logic signed [AW-1:0] ext;
    logic signed [AW-1:0] shd;

    always_comb begin
        ext = {{(AW-CW-1){term[CW]}}, term};
        shd = ext <<< sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (ld) begin
            acc <= ext;
        end else if (en) begin
            acc <= neg ? acc - shd : acc + shd;
        end
    end
endmodule

// File: rtl/dabf_piso.sv
// Parallel-in serial-out register, LSB first, fills with zeros behind the data.
module dabf_piso #(
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          sh,
    input  logic [RW-1:0] din,
    output logic          sout
);
    logic [RW-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (ld) begin
            sr <= din;
        end else if (sh) begin
            sr <= {1'b0, sr[RW-1:1]};
        end
    end

    assign sout = sh ? sr[0] : 1'b0;
endmodule

// File: rtl/dabf_butterfly.sv
module dabf_butterfly
    import dabf_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 10,
    parameter int FRAC = 8,
    parameter logic signed [CW-1:0] COS_C = 10'sd222,
    parameter logic signed [CW-1:0] SIN_C = 10'sd128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_first,
    input  logic a_bit,
    input  logic b_bit,
    output logic done,
    output logic out_vld,
    output logic dif_bit,
    output logic sum_bit
);
    localparam int RW = DW + 1;
    localparam int AW = CW + DW + 1;
    localparam int SW = (DW > 2) ? $clog2(DW) : 1;
    localparam int OW = $clog2(RW);

    dabf_state_t st, st_nx;
    logic [SW-1:0] bcnt;
    logic [OW-1:0] ocnt;
    logic take_first, take_bit, is_msb, last_out;
    logic acc_ld, acc_en, piso_ld, piso_sh;
    logic [1:0] lane_bit;

    assign take_first = (st == ST_IDLE) && bit_vld && bit_first;
    assign take_bit   = (st == ST_ACCUM) && bit_vld;
    assign is_msb     = (bcnt == SW'(DW - 1));
    assign last_out   = (ocnt == OW'(RW - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Transitions: start, msb_done, load, drained
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (take_first)          st_nx = ST_ACCUM;
            ST_ACCUM: if (take_bit && is_msb)  st_nx = ST_DONE;
            ST_DONE:                           st_nx = ST_SHIFT;
            ST_SHIFT: if (last_out)            st_nx = ST_IDLE;
            default:                           st_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        done    = (st == ST_DONE);
        out_vld = (st == ST_SHIFT);
        acc_ld  = take_first;
        acc_en  = take_bit;
        piso_ld = (st == ST_DONE);
        piso_sh = (st == ST_SHIFT);
    end

    // Bit and output counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
            ocnt <= '0;
        end else begin
            if (take_first) begin
                bcnt <= SW'(1);
            end else if (take_bit) begin
                bcnt <= is_msb ? '0 : bcnt + SW'(1);
            end
            if (st == ST_SHIFT) begin
                ocnt <= last_out ? '0 : ocnt + OW'(1);
            end
        end
    end

    // Lane 0: difference term, lane 1: sum term
    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            logic signed [CW:0]   term;
            logic signed [AW-1:0] acc;

            dabf_lut #(
                .CW(CW), .COS_C(COS_C), .SIN_C(SIN_C), .NEG_SIN(g == 0)
            ) u_lut (
                .a_in(a_bit), .b_in(b_bit), .term(term)
            );

            dabf_acc #(
                .CW(CW), .AW(AW), .SW(SW)
            ) u_acc (
                .clk(clk), .rst_n(rst_n), .ld(acc_ld), .en(acc_en),
                .neg(is_msb), .sh(bcnt), .term(term), .acc(acc)
            );

            dabf_piso #(
                .RW(RW)
            ) u_piso (
                .clk(clk), .rst_n(rst_n), .ld(piso_ld), .sh(piso_sh),
                .din(acc[FRAC +: RW]), .sout(lane_bit[g])
            );
        end
    endgenerate

    assign dif_bit = lane_bit[0];
    assign sum_bit = lane_bit[1];
endmodule

// File: rtl/dabf_checker.sv
module dabf_checker #(
    parameter int RW = 9
) (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic out_vld,
    input logic dif_bit,
    input logic sum_bit
);
    localparam int RCW = $clog2(RW + 1) + 1;
    logic [RCW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else begin
            run <= out_vld ? run + RCW'(1) : '0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R6
    AST_DONE_NOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_vld);                                          // R6
    AST_DONE_THEN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> out_vld);                                           // R7
    AST_OUT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(done));                             // R7
    AST_OUT_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (run < RCW'(RW)));                               // R7
    AST_OUT_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_vld)) |-> ($past(run) == RCW'(RW - 1)));          // R7
    AST_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (!dif_bit && !sum_bit));                        // R7
endmodule

bind dabf_butterfly dabf_checker #(.RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .out_vld(out_vld),
    .dif_bit(dif_bit), .sum_bit(sum_bit)
);

// File: tb/dabf_butterfly_tb.sv
module dabf_butterfly_tb;
    localparam int DW = 8;
    localparam int RW = DW + 1;
    localparam int CC = 222;
    localparam int SC = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0, bit_first = 1'b0, a_bit = 1'b0, b_bit = 1'b0;
    logic done, out_vld, dif_bit, sum_bit;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dabf_butterfly u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_first(bit_first),
        .a_bit(a_bit), .b_bit(b_bit), .done(done), .out_vld(out_vld),
        .dif_bit(dif_bit), .sum_bit(sum_bit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One operation: gap inserts an idle cycle with junk after each bit,
    // noise drives start strobes during DONE/SHIFT.
    task automatic run_op(input int a, input int b, input bit gap, input bit noise, input string req);
        logic [DW-1:0] av = DW'(a);
        logic [DW-1:0] bv = DW'(b);
        int pd = a * CC - b * SC;
        int ps = a * CC + b * SC;
        logic [RW-1:0] exp_d = RW'(pd >>> 8);
        logic [RW-1:0] exp_s = RW'(ps >>> 8);
        logic [RW-1:0] got_d = '0;
        logic [RW-1:0] got_s = '0;
        for (int i = 0; i < DW; i++) begin
            @(negedge clk);
            bit_vld = 1'b1; bit_first = (i == 0); a_bit = av[i]; b_bit = bv[i];
            if (gap && i < DW - 1) begin
                @(negedge clk);
                bit_vld = 1'b0; bit_first = 1'b1; a_bit = ~av[i]; b_bit = 1'b1;
                chk("R3", "done during gap", int'(done), 0);
            end
        end
        @(negedge clk);
        bit_vld = noise; bit_first = noise; a_bit = noise; b_bit = noise;
        chk("R6", "done after msb", int'(done), 1);
        chk("R6", "out_vld in done cycle", int'(out_vld), 0);
        for (int j = 0; j < RW; j++) begin
            @(negedge clk);
            if (j == 0) chk("R6", "done width", int'(done), 0);
            chk("R7", "out_vld window", int'(out_vld), 1);
            got_d[j] = dif_bit;
            got_s[j] = sum_bit;
        end
        @(negedge clk);
        bit_vld = 1'b0; bit_first = 1'b0; a_bit = 1'b0; b_bit = 1'b0;
        chk("R7", "out_vld after window", int'(out_vld), 0);
        chk("R7", "lines low after window", int'({dif_bit, sum_bit}), 0);
        chk({"R1 ", req}, $sformatf("dif a=%0d b=%0d", a, b), int'(got_d), int'(exp_d));
        chk({"R2 ", req}, $sformatf("sum a=%0d b=%0d", a, b), int'(got_s), int'(exp_s));
    endtask

    task automatic t_reset();
        #1;
        chk("R9", "reset done", int'(done), 0);
        chk("R9", "reset out_vld", int'(out_vld), 0);
        chk("R9", "reset lines", int'({dif_bit, sum_bit}), 0);
    endtask

    task automatic t_basic();
        run_op(5, 3, 1'b0, 1'b0, "R3 basic");
        run_op(100, -50, 1'b0, 1'b0, "R3 mixed");
        run_op(127, 127, 1'b0, 1'b0, "R3 max");
    endtask

    task automatic t_negative();
        run_op(-128, -128, 1'b0, 1'b0, "R4 min both");
        run_op(-128, 127, 1'b0, 1'b0, "R4 min a");
        run_op(-1, 1, 1'b0, 1'b0, "R4 minus one");
    endtask

    task automatic t_clear();
        run_op(-128, -128, 1'b0, 1'b0, "R5 prior");
        run_op(0, 0, 1'b0, 1'b0, "R5 zero after");
        run_op(1, 0, 1'b0, 1'b0, "R5 small after");
    endtask

    task automatic t_gaps();
        run_op(-77, 91, 1'b1, 1'b0, "R3 gapped");
    endtask

    task automatic t_ignore();
        run_op(42, -99, 1'b0, 1'b1, "R8 noisy");
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R8", "no start from ignored strobe done", int'(done), 0);
            chk("R8", "no start from ignored strobe out_vld", int'(out_vld), 0);
        end
        run_op(-3, -60, 1'b0, 1'b0, "R8 after noise");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_basic();
        t_negative();
        t_clear();
        t_gaps();
        t_ignore();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule